// File: doc/BRIEF.md
# Exhaustive Linear Mask Bias Evaluator

This block counts, for one fixed key of a small substitution-permutation cipher, how many inputs satisfy each of a set of linear approximations. After a start pulse, an internal plaintext counter walks every n-bit value, one per clock. Each value enters a pipelined chain of cipher rounds whose round keys are constants computed at elaboration. The round state is tapped after several consecutive round counts, and each tap has its own group of counters. Every counter belongs to one pairing of an input mask with an output mask. It advances when the parity of the masked plaintext equals the parity of the masked round output.

When the last plaintext has left the deepest tap, a done flag rises. The counters then form a word-wide shift chain, read one word per shift at the chain output. The block is meant to be replicated, one instance per key, and the resulting counts are turned into bias estimates off chip.

Top module: `lin_bias_eval`

## Requirements
- R1: After reset, done_o is low, every counter is zero, and no counter moves until a start is accepted.
- R2: An accepted start sweeps the plaintexts 0, 1, ..., 2^N_BITS-1 in order, one per clock cycle, each exactly once.
- R3: Stage 0 of the round chain only XORs round key 0 into the plaintext. Each later stage r applies the S-box layer, then the bit permutation, then XORs round key r. Round key r is the low N_BITS bits of KEY_SEED XOR (r * 64'h9E3779B97F4A7C15), computed modulo 2^64.
- R4: The S-box maps nibble values 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 and is applied to every nibble. The permutation moves bit b (b < N_BITS-1) to bit (b*N_BITS/4) mod (N_BITS-1), and leaves bit N_BITS-1 in place.
- R5: Outputs are tapped after rounds FIRST_TAP through FIRST_TAP+N_TAPS-1 (8 to 12 by default). Each tap feeds its own counter group.
- R6: Input mask i is the low N_BITS bits of IN_MASKS[64i+63:64i], and output mask j is taken the same way from OUT_MASKS. Counter (tap t, pair p = i*N_OUT+j) adds one for a plaintext x with tapped output y exactly when parity(x & in mask i) equals parity(y & out mask j).
- R7: Counters are N_BITS+1 bits wide, so a pair that agrees on every input reads exactly 2^N_BITS.
- R8: Counter k = t*N_IN*N_OUT + p sits at position k of the chain, and chain_o shows the last counter. While idle, each clock with shift_i high moves every counter into the next position, and chain_i enters position 0. With shift_i low, chain_o holds its value.
- R9: While a sweep is active (from an accepted start until done), shift_i and start_i are ignored: the plaintext sequence is not restarted and no counter shifts.
- R10: An accepted start clears done_o and all counters on its clock edge. done_o rises on the edge 2^N_BITS+13 clock edges after that start edge, for the default tap range. It then stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a sweep when the block is idle |
| shift_i | input | 1 | Advances the counter chain by one word when idle |
| chain_i | input | N_BITS+1 | Word loaded into chain position 0 on a shift |
| chain_o | output | N_BITS+1 | Value of the last counter in the chain |
| done_o | output | 1 | High once a sweep has drained completely |

## Verification
The bench builds the block at its narrowest legal width, 16 bits, with the default taps after rounds 8 to 12 and two input and two output masks. One of each mask set is zero. This keeps a full sweep to about 65,000 cycles, so two complete sweeps fit in one run. The zero masks give exact expected counts: 2^16 for the all-zero pair and half that for a pair with one zero mask, because the cipher is a bijection. These exact counts expose sweep coverage and counter-width errors without any model. The two nonzero masks are checked against a model of the cipher that the bench evaluates itself. This makes round order, S-box, permutation and key errors visible at every tap.

// File: rtl/lbe_pkg.sv
// Shared helpers for the linear mask bias evaluator.
// Assumes widths are multiples of four and at most 64 bits.
package lbe_pkg;

    // Fixed 4-bit substitution applied to every nibble
    function automatic logic [3:0] sbox(input logic [3:0] v);
        case (v)
            4'h0: sbox = 4'hC;  4'h1: sbox = 4'h5;  4'h2: sbox = 4'h6;  4'h3: sbox = 4'hB;
            4'h4: sbox = 4'h9;  4'h5: sbox = 4'h0;  4'h6: sbox = 4'hA;  4'h7: sbox = 4'hD;
            4'h8: sbox = 4'h3;  4'h9: sbox = 4'hE;  4'hA: sbox = 4'hF;  4'hB: sbox = 4'h8;
            4'hC: sbox = 4'h4;  4'hD: sbox = 4'h7;  4'hE: sbox = 4'h1;  default: sbox = 4'h2;
        endcase
    endfunction

    // Destination bit of source bit b in the width-n permutation
    function automatic int perm_dst(input int b, input int n);
        if (b == n - 1) return n - 1;
        return (b * (n / 4)) % (n - 1);
    endfunction

    // Round key r derived from a 64-bit seed (truncated by the user)
    function automatic logic [63:0] round_key(input logic [63:0] seed, input int r);
        return seed ^ (64'h9E37_79B9_7F4A_7C15 * 64'(r));
    endfunction

endpackage

// File: rtl/lbe_sweep.sv
// Sweep controller: walks the plaintext space once per accepted start,
// tracks the active window and the done flag.
// Assumes drain_last_i pulses once, when the final plaintext leaves the last tap.
module lbe_sweep #(
    parameter int N_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              drain_last_i,
    output logic              clr_o,
    output logic              active_o,
    output logic              run_o,
    output logic [N_BITS-1:0] pt_o,
    output logic              done_o
);
    localparam logic [N_BITS-1:0] PT_LAST = '1;

    // A start is honoured only when no sweep is in flight
    assign clr_o = start_i & ~active_o;

    // Plaintext counter, run window, active window and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            run_o    <= 1'b0;
            pt_o     <= '0;
            done_o   <= 1'b0;
        end else if (clr_o) begin
            active_o <= 1'b1;
            run_o    <= 1'b1;
            pt_o     <= '0;
            done_o   <= 1'b0;
        end else begin
            if (run_o) begin
                pt_o <= pt_o + 1'b1;
                if (pt_o == PT_LAST) run_o <= 1'b0;
            end
            if (drain_last_i) begin
                active_o <= 1'b0;
                done_o   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbe_stage.sv
// One registered cipher stage. It carries the plaintext and a valid bit
// alongside the state. With KEY_ONLY set it only adds KEY; otherwise it
// applies the S-box layer, the bit permutation, then the key.
// Assumes N_BITS is a multiple of four.
module lbe_stage #(
    parameter int              N_BITS   = 16,
    parameter logic [N_BITS-1:0] KEY    = '0,
    parameter bit              KEY_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [N_BITS-1:0] pt_i,
    input  logic [N_BITS-1:0] st_i,
    output logic              valid_o,
    output logic [N_BITS-1:0] pt_o,
    output logic [N_BITS-1:0] st_o
);
    localparam int NIB = N_BITS / 4;

    logic [N_BITS-1:0] mixed;

    generate
        if (KEY_ONLY) begin : g_key_only
            assign mixed = st_i;
        end else begin : g_round
            logic [N_BITS-1:0] subd;
            for (genvar q = 0; q < NIB; q++) begin : g_sub
                assign subd[4*q +: 4] = lbe_pkg::sbox(st_i[4*q +: 4]);
            end
            for (genvar b = 0; b < N_BITS; b++) begin : g_perm
                assign mixed[lbe_pkg::perm_dst(b, N_BITS)] = subd[b];
            end
        end
    endgenerate

    // Register the keyed state together with its plaintext and valid bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            pt_o    <= '0;
            st_o    <= '0;
        end else begin
            valid_o <= valid_i;
            pt_o    <= pt_i;
            st_o    <= mixed ^ KEY;
        end
    end
endmodule

// File: rtl/lbe_tally.sv
// Counter group for one round tap: one counter per input/output mask pair.
// The group is one segment of the readout chain.
// Assumes shift_i and valid_i are never high together (the top gates shift).
module lbe_tally #(
    parameter int                  N_BITS    = 16,
    parameter int                  N_IN      = 2,
    parameter int                  N_OUT     = 2,
    parameter logic [N_IN*64-1:0]  IN_MASKS  = '0,
    parameter logic [N_OUT*64-1:0] OUT_MASKS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              valid_i,
    input  logic [N_BITS-1:0] pt_i,
    input  logic [N_BITS-1:0] st_i,
    input  logic [N_BITS:0]   chain_i,
    output logic [N_BITS:0]   chain_o
);
    localparam int NP = N_IN * N_OUT;
    localparam int CW = N_BITS + 1;

    logic [N_IN-1:0]  a_par;
    logic [N_OUT-1:0] b_par;
    logic [CW-1:0]    cnt [NP];

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_apar
            localparam logic [N_BITS-1:0] AM = N_BITS'(IN_MASKS[64*i +: 64]);
            assign a_par[i] = ^(pt_i & AM);
        end
        for (genvar j = 0; j < N_OUT; j++) begin : g_bpar
            localparam logic [N_BITS-1:0] BM = N_BITS'(OUT_MASKS[64*j +: 64]);
            assign b_par[j] = ^(st_i & BM);
        end
    endgenerate

    // Clear, shift along the chain, or count parity agreement
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int p = 0; p < NP; p++) cnt[p] <= '0;
        end else if (shift_i) begin
            cnt[0] <= chain_i;
            for (int p = 1; p < NP; p++) cnt[p] <= cnt[p-1];
        end else if (valid_i) begin
            for (int i = 0; i < N_IN; i++)
                for (int j = 0; j < N_OUT; j++)
                    if (a_par[i] == b_par[j]) cnt[i*N_OUT+j] <= cnt[i*N_OUT+j] + 1'b1;
        end
    end

    assign chain_o = cnt[NP-1];
endmodule

// File: rtl/lin_bias_eval.sv
// Exhaustive linear mask bias evaluator for one hard-coded key.
// It sweeps every plaintext through a pipelined round chain and counts
// parity agreement per mask pair at each tapped round. Results are read
// out through a word-wide shift chain.
// Assumes N_BITS is a multiple of four (16..40) and FIRST_TAP >= 1.
module lin_bias_eval #(
    parameter int                  N_BITS    = 16,
    parameter int                  FIRST_TAP = 8,
    parameter int                  N_TAPS    = 5,
    parameter int                  N_IN      = 2,
    parameter int                  N_OUT     = 2,
    parameter logic [63:0]         KEY_SEED  = 64'h5A17_C3E9_0B62_D48F,
    parameter logic [N_IN*64-1:0]  IN_MASKS  = {64'h0000_0000_0000_00F0, 64'h0},
    parameter logic [N_OUT*64-1:0] OUT_MASKS = {64'h0000_0000_0000_0101, 64'h0}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            shift_i,
    input  logic [N_BITS:0] chain_i,
    output logic [N_BITS:0] chain_o,
    output logic            done_o
);
    localparam int CW    = N_BITS + 1;
    localparam int DEPTH = FIRST_TAP + N_TAPS - 1;
    localparam logic [N_BITS-1:0] PT_LAST = '1;

    logic              clr;
    logic              active;
    logic              run;
    logic [N_BITS-1:0] pt;
    logic              drain_last;
    logic              shift_en;

    logic              stg_v  [DEPTH+1];
    logic [N_BITS-1:0] stg_pt [DEPTH+1];
    logic [N_BITS-1:0] stg_st [DEPTH+1];
    logic [CW-1:0]     link   [N_TAPS+1];

    assign drain_last = stg_v[DEPTH] && (stg_pt[DEPTH] == PT_LAST);
    assign shift_en   = shift_i & ~active;

    lbe_sweep #(.N_BITS(N_BITS)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .drain_last_i (drain_last),
        .clr_o        (clr),
        .active_o     (active),
        .run_o        (run),
        .pt_o         (pt),
        .done_o       (done_o)
    );

    generate
        for (genvar s = 0; s <= DEPTH; s++) begin : g_stage
            localparam logic [N_BITS-1:0] RK = N_BITS'(lbe_pkg::round_key(KEY_SEED, s));
            if (s == 0) begin : g_first
                lbe_stage #(.N_BITS(N_BITS), .KEY(RK), .KEY_ONLY(1'b1)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .valid_i(run), .pt_i(pt), .st_i(pt),
                    .valid_o(stg_v[s]), .pt_o(stg_pt[s]), .st_o(stg_st[s])
                );
            end else begin : g_next
                lbe_stage #(.N_BITS(N_BITS), .KEY(RK), .KEY_ONLY(1'b0)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .valid_i(stg_v[s-1]), .pt_i(stg_pt[s-1]), .st_i(stg_st[s-1]),
                    .valid_o(stg_v[s]), .pt_o(stg_pt[s]), .st_o(stg_st[s])
                );
            end
        end

        assign link[0] = chain_i;
        for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
            lbe_tally #(
                .N_BITS(N_BITS), .N_IN(N_IN), .N_OUT(N_OUT),
                .IN_MASKS(IN_MASKS), .OUT_MASKS(OUT_MASKS)
            ) u_tally (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (clr),
                .shift_i (shift_en),
                .valid_i (stg_v[FIRST_TAP+t]),
                .pt_i    (stg_pt[FIRST_TAP+t]),
                .st_i    (stg_st[FIRST_TAP+t]),
                .chain_i (link[t]),
                .chain_o (link[t+1])
            );
        end
    endgenerate

    assign chain_o = link[N_TAPS];
endmodule

// File: rtl/lbe_checker.sv
// Temporal checks on the evaluator: sweep stepping, done handling,
// start filtering and chain stability. Bound to lin_bias_eval below.
module lbe_checker #(
    parameter int N_BITS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              shift_i,
    input logic [N_BITS:0]   chain_o,
    input logic              done_o,
    input logic              active,
    input logic              run,
    input logic [N_BITS-1:0] pt
);
    localparam logic [N_BITS-1:0] PT_LAST = '1;

    // R2: plaintext advances by exactly one per cycle during the sweep
    p_sweep_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && pt != PT_LAST |=> run && pt == N_BITS'($past(pt) + 1'b1));

    // R9: a start while busy keeps the sweep active
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active && start_i && !done_o |=> active || done_o);

    // R8: idle chain without shift or start holds its output
    p_chain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !shift_i && !start_i |=> $stable(chain_o));

    // R10: an accepted start clears done and opens the active window
    p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !active |=> active && !done_o);

    // R10: done holds until the next start
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    // R10: done and active never overlap
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !active);
endmodule

bind lin_bias_eval lbe_checker #(.N_BITS(N_BITS)) u_lbe_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .shift_i (shift_i),
    .chain_o (chain_o),
    .done_o  (done_o),
    .active  (active),
    .run     (run),
    .pt      (pt)
);

// File: tb/test_lin_bias_eval.sv
`timescale 1ns/1ps
module test_lin_bias_eval;
    localparam int NB    = 16;
    localparam int CW    = NB + 1;
    localparam int FT    = 8;
    localparam int NT    = 5;
    localparam int NI    = 2;
    localparam int NO    = 2;
    localparam int NP    = NI * NO;
    localparam int NC    = NT * NP;
    localparam int SWEEP = 1 << NB;
    localparam logic [63:0] SEED = 64'h5A17_C3E9_0B62_D48F;
    localparam logic [CW-1:0] FILL = 17'h1ABCD;

    logic clk = 1'b0;
    logic rst_n, start_i, shift_i;
    logic [CW-1:0] chain_i, chain_o;
    logic done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int exp_cnt [NC];
    logic [NB-1:0] in_m  [NI] = '{16'h0000, 16'h00F0};
    logic [NB-1:0] out_m [NO] = '{16'h0000, 16'h0101};
    logic [3:0] sb [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                            4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

    always #2.5 clk = ~clk;

    lin_bias_eval #(
        .N_BITS(NB), .FIRST_TAP(FT), .N_TAPS(NT), .N_IN(NI), .N_OUT(NO),
        .KEY_SEED(SEED),
        .IN_MASKS({64'h0000_0000_0000_00F0, 64'h0}),
        .OUT_MASKS({64'h0000_0000_0000_0101, 64'h0})
    ) i_lin_bias_eval (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shift_i(shift_i),
        .chain_i(chain_i), .chain_o(chain_o), .done_o(done_o)
    );

    function automatic logic [NB-1:0] mkey(int r);
        logic [63:0] k;
        k = SEED ^ (64'h9E37_79B9_7F4A_7C15 * 64'(r));
        return k[NB-1:0];
    endfunction

    function automatic logic [NB-1:0] mround(logic [NB-1:0] x, int r);
        logic [NB-1:0] s, p;
        for (int q = 0; q < NB/4; q++) s[4*q +: 4] = sb[x[4*q +: 4]];
        p = '0;
        for (int b = 0; b < NB; b++) begin
            if (b == NB-1) p[b] = s[b];
            else p[(b * (NB/4)) % (NB-1)] = s[b];
        end
        return p ^ mkey(r);
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected counts from the cipher and counting rules (R3 R4 R5 R6)
    task automatic build_model();
        for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
        for (int p = 0; p < SWEEP; p++) begin
            logic [NB-1:0] x;
            x = NB'(p) ^ mkey(0);
            for (int r = 1; r < FT + NT; r++) begin
                x = mround(x, r);
                if (r >= FT) begin
                    for (int i = 0; i < NI; i++)
                        for (int j = 0; j < NO; j++)
                            if ((^(NB'(p) & in_m[i])) == (^(x & out_m[j])))
                                exp_cnt[(r-FT)*NP + i*NO + j]++;
                end
            end
        end
    endtask

    // R1: reset state and no activity without a start
    task automatic test_reset();
        rst_n = 1'b0; start_i = 1'b0; shift_i = 1'b0; chain_i = FILL;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R1 done after reset", done_o, 0);
        check("R1 chain after reset", chain_o, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R1 idle chain", chain_o, 0);
        check("R1 idle done", done_o, 0);
    endtask

    // R10 (and R9 when disturb is set): start, run to done, time the flag
    task automatic test_sweep(input bit disturb);
        @(negedge clk);
        start_i = 1'b1;
        shift_i = disturb;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R10 done cleared by start", done_o, 0);
        check("R10 counters cleared by start", chain_o, 0);
        for (int k = 1; k <= SWEEP + 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (disturb) begin
                if (k == 500) start_i = 1'b1;
                if (k == 501) start_i = 1'b0;
                if (k == 2000) shift_i = 1'b0;
            end
        end
        check(disturb ? "R9 R10 done not early" : "R10 done not early", done_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(disturb ? "R9 R10 done on time" : "R10 done on time", done_o, 1);
    endtask

    // R8 readout order; counts check R2 R3 R4 R5 R6 R7
    task automatic test_readout(input string tag);
        for (int k = 0; k < NC; k++) begin
            int idx;
            string req;
            idx = NC - 1 - k;
            case (idx % NP)
                0:       req = "R2 R7 zero-mask pair";
                1, 2:    req = "R6 one-zero-mask pair";
                default: req = "R3 R4 R5 masked pair";
            endcase
            check($sformatf("%s %s tap%0d pair%0d", tag, req, idx / NP, idx % NP),
                  chain_o, exp_cnt[idx]);
            shift_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            shift_i = 1'b0;
        end
        check({tag, " R8 chain input reaches tail"}, chain_o, FILL);
    endtask

    // R8: idle chain without shift holds even when chain_i changes
    task automatic test_hold();
        chain_i = 17'h00F3C;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R8 hold without shift", chain_o, FILL);
        chain_i = FILL;
    endtask

    initial begin
        test_reset();
        build_model();
        check("R7 model zero pair equals full space", exp_cnt[0], SWEEP);
        test_sweep(1'b0);
        test_readout("sweep1");
        test_hold();
        test_sweep(1'b1);
        test_readout("sweep2 R9");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule